// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns single CPU memory requests into bus cycles on an external memory interface whose low address byte and data byte share eight bidirectional lines. The upper address bits leave on a separate port, so a 13-bit request reaches an 8 KB space. The bus has an address strobe, a data strobe, a read/write line and a line that tells data-memory accesses apart from program-memory accesses. The block does not drive pads. It gives an output value, an output enable and an input sample for the shared lines.

A cycle passes through five phases in a fixed order. First the address is driven with the address strobe low. Then the shared lines float with both strobes high. The data phase follows with the data strobe low. It is longer for reads than for writes, and a write has one extra set-up clock in which the data is driven before the strobe falls. A recovery gap with both strobes high ends the cycle. A 2-bit wait count, captured when the request is accepted, stretches only the data-strobe low time. Read data is taken at the clock edge where the data strobe rises. A one-clock done pulse marks the return to idle, and a new request may be accepted in that same clock.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is held, and when idle, as_n_o=1, ds_n_o=1, ad_oe_o=0, done_o=0, rw_o=1, dmsel_o=1, ahi_o=0.
- R2: A request seen with req_i=1 in an idle clock starts a cycle at that edge. For the next ADDR_CLKS clocks as_n_o=0, ad_oe_o=1, ad_o=address bits 7:0 and ahi_o=address bits 12:8.
- R3: After the address strobe rises, FLOAT_CLKS clocks follow with ad_oe_o=0 and both strobes high, before the data phase begins.
- R4: as_n_o and ds_n_o are never low in the same clock.
- R5: In a read, ds_n_o is low for RD_DS_CLKS + N*WAIT_CLKS consecutive clocks, N being the captured wait count (0 to 3). ad_oe_o stays 0 through the data phase and the recovery gap.
- R6: In a write, one set-up clock with ad_oe_o=1, ad_o=write data and ds_n_o=1 comes first. Then ds_n_o is low for WR_DS_CLKS + N*WAIT_CLKS clocks, and the write data stays driven through the recovery gap that follows.
- R7: rdata_o takes the ad_i value present in the last clock in which ds_n_o is low, at the edge where ds_n_o rises. It then holds until the next read completes. Writes leave it unchanged.
- R8: After the data phase, REC_CLKS clocks with both strobes high follow. Then done_o=1 for exactly one clock, the first idle clock, and a request in that clock is accepted.
- R9: rw_o is 1 for a read and 0 for a write. dmsel_o is 0 for a data-memory access and 1 for program memory, with the default active-low polarity. ahi_o, rw_o and dmsel_o stay constant for the whole cycle.
- R10: Address, data, direction, space and wait count are captured at acceptance. A req_i pulse or a change of any request input while a cycle runs has no effect on that cycle and starts no further cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request, sampled only in idle clocks |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_dmem_i | input | 1 | 1 = data memory, 0 = program memory |
| req_addr_i | input | ADDR_W (13) | Request address |
| req_wdata_i | input | DATA_W (8) | Write data |
| wait_cnt_i | input | WAIT_W (2) | Number of wait states N |
| rdata_o | output | DATA_W (8) | Last read data |
| done_o | output | 1 | One-clock completion pulse |
| ahi_o | output | ADDR_W-DATA_W (5) | Upper address bits |
| ad_o | output | DATA_W (8) | Shared lines, output value |
| ad_oe_o | output | 1 | Shared lines, output enable |
| ad_i | input | DATA_W (8) | Shared lines, input value |
| as_n_o | output | 1 | Address strobe, active low |
| ds_n_o | output | 1 | Data strobe, active low |
| rw_o | output | 1 | 1 = read, 0 = write |
| dmsel_o | output | 1 | Space select, data memory when low |

## Verification
The bench builds the block with WAIT_CLKS=3, which is not a power of two, so the multiplier path of the wait extension is used. Data phases then reach thirteen clocks, and every wait count from 0 to 3 gives a distinct strobe length. The other phase lengths keep their defaults. A sweep over all wait counts, both directions, both spaces and the all-zero, all-one and alternating addresses checks every output in every clock of each cycle. The shared input lines change value each clock, so a sample taken one edge early or late shows as a wrong read value. Separate runs issue requests while a cycle is in progress and issue a request in the done clock.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ADDR  = 3'd1,
      ST_FLOAT = 3'd2,
      ST_DATA  = 3'd3,
      ST_RECOV = 3'd4
   } xbus_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/xbus_req_latch.sv
module xbus_req_latch #(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8,
   parameter int WAIT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              we_i,
   input  logic              dmem_i,
   input  logic [WAIT_W-1:0] wait_i,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              we_q,
   output logic              dmem_q,
   output logic [WAIT_W-1:0] wait_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         we_q    <= 1'b0;
         dmem_q  <= 1'b0;
         wait_q  <= '0;
      end else if (load_i) begin
         addr_q  <= addr_i;
         wdata_q <= wdata_i;
         we_q    <= we_i;
         dmem_q  <= dmem_i;
         wait_q  <= wait_i;
      end
   end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int WAIT_W     = 2,
   parameter int ADDR_CLKS  = 2,
   parameter int FLOAT_CLKS = 1,
   parameter int RD_DS_CLKS = 4,
   parameter int WR_DS_CLKS = 2,
   parameter int WAIT_CLKS  = 1,
   parameter int REC_CLKS   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              we_q,
   input  logic [WAIT_W-1:0] wait_q,
   output xbus_state_e       state_o,
   output logic              accept_o,
   output logic              setup_o,
   output logic              last_data_o,
   output logic              done_o
);

   localparam int EXT_MAX  = ((1 << WAIT_W) - 1) * WAIT_CLKS;
   localparam int DATA_MAX = imax(RD_DS_CLKS, WR_DS_CLKS + 1) + EXT_MAX;
   localparam int LEN_MAX  = imax(imax(ADDR_CLKS, FLOAT_CLKS), imax(REC_CLKS, DATA_MAX));
   localparam int CNT_W    = $clog2(LEN_MAX + 1);
   localparam bit WC_POW2  = (WAIT_CLKS & (WAIT_CLKS - 1)) == 0;

   xbus_state_e      state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] len;
   logic [CNT_W-1:0] ext;
   logic             phase_end;

   generate
      if (WC_POW2) begin : g_ext_shift
         assign ext = CNT_W'(wait_q) << $clog2(WAIT_CLKS);
      end else begin : g_ext_mul
         assign ext = CNT_W'(wait_q) * CNT_W'(WAIT_CLKS);
      end
   endgenerate

   always_comb begin
      case (state)
         ST_ADDR:  len = CNT_W'(ADDR_CLKS);
         ST_FLOAT: len = CNT_W'(FLOAT_CLKS);
         ST_DATA:  len = (we_q ? CNT_W'(WR_DS_CLKS + 1) : CNT_W'(RD_DS_CLKS)) + ext;
         ST_RECOV: len = CNT_W'(REC_CLKS);
         default:  len = CNT_W'(1);
      endcase
   end

   assign phase_end   = (cnt == len - 1'b1);
   assign accept_o    = (state == ST_IDLE) && req_i;
   assign setup_o     = (state == ST_DATA) && we_q && (cnt == '0);
   assign last_data_o = (state == ST_DATA) && phase_end;
   assign state_o     = state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (state == ST_IDLE) begin
            cnt <= '0;
            if (req_i) state <= ST_ADDR;
         end else if (phase_end) begin
            cnt <= '0;
            case (state)
               ST_ADDR:  state <= ST_FLOAT;
               ST_FLOAT: state <= ST_DATA;
               ST_DATA:  state <= ST_RECOV;
               default: begin
                  state  <= ST_IDLE;
                  done_o <= 1'b1;
               end
            endcase
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/xbus_pads.sv
module xbus_pads
   import xbus_pkg::*;
#(
   parameter int ADDR_W        = 13,
   parameter int DATA_W        = 8,
   parameter bit DM_ACTIVE_LOW = 1'b1
) (
   input  xbus_state_e              state_i,
   input  logic                     setup_i,
   input  logic [ADDR_W-1:0]        addr_q,
   input  logic [DATA_W-1:0]        wdata_q,
   input  logic                     we_q,
   input  logic                     dmem_q,
   output logic [ADDR_W-DATA_W-1:0] ahi_o,
   output logic [DATA_W-1:0]        ad_o,
   output logic                     ad_oe_o,
   output logic                     as_n_o,
   output logic                     ds_n_o,
   output logic                     rw_o,
   output logic                     dmsel_o
);

   logic busy;
   logic wr_drive;
   logic dm_on;

   assign busy     = (state_i != ST_IDLE);
   assign wr_drive = we_q && ((state_i == ST_DATA) || (state_i == ST_RECOV));
   assign dm_on    = busy && dmem_q;

   assign ahi_o   = busy ? addr_q[ADDR_W-1:DATA_W] : '0;
   assign as_n_o  = (state_i != ST_ADDR);
   assign ds_n_o  = !((state_i == ST_DATA) && !setup_i);
   assign ad_oe_o = (state_i == ST_ADDR) || wr_drive;
   assign ad_o    = (state_i == ST_ADDR) ? addr_q[DATA_W-1:0] :
                    wr_drive             ? wdata_q : '0;
   assign rw_o    = busy ? !we_q : 1'b1;

   generate
      if (DM_ACTIVE_LOW) begin : g_dm_low
         assign dmsel_o = !dm_on;
      end else begin : g_dm_high
         assign dmsel_o = dm_on;
      end
   endgenerate

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
   import xbus_pkg::*;
#(
   parameter int ADDR_W        = 13,
   parameter int DATA_W        = 8,
   parameter int WAIT_W        = 2,
   parameter int ADDR_CLKS     = 2,
   parameter int FLOAT_CLKS    = 1,
   parameter int RD_DS_CLKS    = 4,
   parameter int WR_DS_CLKS    = 2,
   parameter int WAIT_CLKS     = 1,
   parameter int REC_CLKS      = 2,
   parameter bit DM_ACTIVE_LOW = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_i,
   input  logic                     req_we_i,
   input  logic                     req_dmem_i,
   input  logic [ADDR_W-1:0]        req_addr_i,
   input  logic [DATA_W-1:0]        req_wdata_i,
   input  logic [WAIT_W-1:0]        wait_cnt_i,
   output logic [DATA_W-1:0]        rdata_o,
   output logic                     done_o,
   output logic [ADDR_W-DATA_W-1:0] ahi_o,
   output logic [DATA_W-1:0]        ad_o,
   output logic                     ad_oe_o,
   input  logic [DATA_W-1:0]        ad_i,
   output logic                     as_n_o,
   output logic                     ds_n_o,
   output logic                     rw_o,
   output logic                     dmsel_o
);

   generate
      if (ADDR_W <= DATA_W) begin : g_bad_width
         $error("xbus_ctrl: ADDR_W must exceed DATA_W");
      end
      if (ADDR_CLKS < 1 || FLOAT_CLKS < 1 || RD_DS_CLKS < 1 ||
          WR_DS_CLKS < 1 || WAIT_CLKS < 1 || REC_CLKS < 1) begin : g_bad_len
         $error("xbus_ctrl: every phase length must be at least one clock");
      end
      if (WAIT_W < 1) begin : g_bad_wait
         $error("xbus_ctrl: WAIT_W must be at least 1");
      end
   endgenerate

   xbus_state_e       state;
   logic              accept;
   logic              setup;
   logic              last_data;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              we_q;
   logic              dmem_q;
   logic [WAIT_W-1:0] wait_q;

   xbus_req_latch #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .WAIT_W (WAIT_W)
   ) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept),
      .addr_i  (req_addr_i),
      .wdata_i (req_wdata_i),
      .we_i    (req_we_i),
      .dmem_i  (req_dmem_i),
      .wait_i  (wait_cnt_i),
      .addr_q  (addr_q),
      .wdata_q (wdata_q),
      .we_q    (we_q),
      .dmem_q  (dmem_q),
      .wait_q  (wait_q)
   );

   xbus_seq #(
      .WAIT_W     (WAIT_W),
      .ADDR_CLKS  (ADDR_CLKS),
      .FLOAT_CLKS (FLOAT_CLKS),
      .RD_DS_CLKS (RD_DS_CLKS),
      .WR_DS_CLKS (WR_DS_CLKS),
      .WAIT_CLKS  (WAIT_CLKS),
      .REC_CLKS   (REC_CLKS)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req_i),
      .we_q        (we_q),
      .wait_q      (wait_q),
      .state_o     (state),
      .accept_o    (accept),
      .setup_o     (setup),
      .last_data_o (last_data),
      .done_o      (done_o)
   );

   xbus_pads #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .DM_ACTIVE_LOW (DM_ACTIVE_LOW)
   ) u_pads (
      .state_i (state),
      .setup_i (setup),
      .addr_q  (addr_q),
      .wdata_q (wdata_q),
      .we_q    (we_q),
      .dmem_q  (dmem_q),
      .ahi_o   (ahi_o),
      .ad_o    (ad_o),
      .ad_oe_o (ad_oe_o),
      .as_n_o  (as_n_o),
      .ds_n_o  (ds_n_o),
      .rw_o    (rw_o),
      .dmsel_o (dmsel_o)
   );

   // read sample taken on the edge that ends the data strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_o <= '0;
      end else if (last_data && !we_q) begin
         rdata_o <= ad_i;
      end
   end

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
   parameter int HI_W = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            as_n_o,
   input logic            ds_n_o,
   input logic            ad_oe_o,
   input logic            rw_o,
   input logic            dmsel_o,
   input logic [HI_W-1:0] ahi_o,
   input logic            done_o
);

   // R2
   as_fall_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(as_n_o) |-> ad_oe_o);

   // R3
   float_after_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(as_n_o) |-> (!ad_oe_o && ds_n_o));

   // R4
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!as_n_o && !ds_n_o));

   // R5
   read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ds_n_o && rw_o) |-> !ad_oe_o);

   // R6
   write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ds_n_o) && !rw_o) |-> ad_oe_o);

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (as_n_o && ds_n_o && !ad_oe_o));

   // R9
   ctrl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ds_n_o |-> ($stable(ahi_o) && $stable(rw_o) && $stable(dmsel_o)));

endmodule

bind xbus_ctrl xbus_ctrl_chk #(.HI_W(ADDR_W - DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .as_n_o  (as_n_o),
   .ds_n_o  (ds_n_o),
   .ad_oe_o (ad_oe_o),
   .rw_o    (rw_o),
   .dmsel_o (dmsel_o),
   .ahi_o   (ahi_o),
   .done_o  (done_o)
);

// File: tb/xbus_ctrl_tb.sv
`timescale 1ns/1ps
module xbus_ctrl_tb;

   localparam int AC = 2;
   localparam int FC = 1;
   localparam int RC = 4;
   localparam int WC = 2;
   localparam int XC = 3;
   localparam int GC = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        we = 1'b0;
   logic        dm = 1'b0;
   logic [12:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [1:0]  wt = '0;
   logic [7:0]  ad_in = '0;
   logic [7:0]  rdata;
   logic        done;
   logic [4:0]  ahi;
   logic [7:0]  ad;
   logic        ad_oe, as_n, ds_n, rw, dmsel;

   int total = 0;
   int bad = 0;
   logic [7:0] exp_rdata = 8'h00;
   bit finished = 1'b0;

   logic        nx_we, nx_dm;
   logic [12:0] nx_addr;
   logic [7:0]  nx_wdata;
   logic [1:0]  nx_wt;

   always #2.5 clk = ~clk;

   xbus_ctrl #(
      .ADDR_CLKS (AC), .FLOAT_CLKS (FC), .RD_DS_CLKS (RC),
      .WR_DS_CLKS (WC), .WAIT_CLKS (XC), .REC_CLKS (GC)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .req_i (req), .req_we_i (we),
      .req_dmem_i (dm), .req_addr_i (addr), .req_wdata_i (wdata),
      .wait_cnt_i (wt), .rdata_o (rdata), .done_o (done), .ahi_o (ahi),
      .ad_o (ad), .ad_oe_o (ad_oe), .ad_i (ad_in), .as_n_o (as_n),
      .ds_n_o (ds_n), .rw_o (rw), .dmsel_o (dmsel)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] pat(input int k, input logic [12:0] a);
      return 8'((k * 37) ^ int'(a[7:0]) ^ 8'h5A);
   endfunction

   task automatic idle_chk(input string tag);
      chk(tag, {28'd0, as_n, ds_n, ad_oe, done}, {28'd0, 4'b1100});
      chk(tag, {24'd0, ahi, rw, dmsel}, {24'd0, 5'd0, 2'b11});
   endtask

   // one full bus cycle, checked in every clock
   task automatic run_txn(input logic t_we, input logic t_dm, input logic [12:0] t_addr,
                          input logic [7:0] t_wd, input logic [1:0] t_wt,
                          input bit interfere, input bit issued, input bit chain);
      int d, l;
      string ph;
      logic e_as, e_ds, e_oe;
      d = (t_we ? WC + 1 : RC) + int'(t_wt) * XC;
      l = AC + FC + d + GC;
      if (!issued) begin
         @(negedge clk);
         req = 1'b1; we = t_we; dm = t_dm; addr = t_addr; wdata = t_wd; wt = t_wt;
      end
      for (int k = 1; k <= l + 1; k++) begin
         @(negedge clk);
         e_as = !(k <= AC);
         e_ds = !((k > AC + FC) && (k <= AC + FC + d) && !(t_we && k == AC + FC + 1));
         e_oe = (k <= AC) || (t_we && (k > AC + FC) && (k <= l));
         if (k <= AC) ph = "R2 addr";
         else if (k <= AC + FC) ph = "R3 float";
         else if (k <= AC + FC + d) ph = t_we ? "R6 write data" : "R5 read data";
         else if (k <= l) ph = "R8 recovery";
         else ph = "R8 done";
         chk(ph, {29'd0, as_n, ds_n, ad_oe}, {29'd0, e_as, e_ds, e_oe});
         if (e_oe) chk({ph, " ad"}, {24'd0, ad}, {24'd0, (k <= AC) ? t_addr[7:0] : t_wd});
         chk("R4 strobes", {31'd0, as_n | ds_n}, 32'd1);
         if (k <= l)
            chk("R9 ctrl", {24'd0, ahi, rw, dmsel}, {24'd0, t_addr[12:8], !t_we, !t_dm});
         chk("R8 done pulse", {31'd0, done}, {31'd0, k == l + 1});
         if (k == 1) begin
            req = 1'b0;
            if (interfere) begin
               wt = ~t_wt; we = ~t_we; dm = ~t_dm; addr = ~t_addr; wdata = ~t_wd;
            end
         end
         if (interfere && k == 3) req = 1'b1;
         if (interfere && k == 4) req = 1'b0;
         ad_in = pat(k, t_addr);
         if (chain && k == l + 1) begin
            req = 1'b1; we = nx_we; dm = nx_dm; addr = nx_addr; wdata = nx_wdata; wt = nx_wt;
         end
      end
      if (!t_we) exp_rdata = pat(AC + FC + d, t_addr);
      // sampled at the edge where the strobe rises; writes leave it alone
      chk("R7 rdata", {24'd0, rdata}, {24'd0, exp_rdata});
      if (!chain) begin
         @(negedge clk);
         idle_chk(interfere ? "R10 no extra cycle" : "R1 idle after");
         @(negedge clk);
         idle_chk(interfere ? "R10 no extra cycle" : "R1 idle after");
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [12:0] adrs [4];
      adrs[0] = 13'h0000; adrs[1] = 13'h1FFF; adrs[2] = 13'h0AA5; adrs[3] = 13'h155A;
      repeat (2) @(negedge clk);
      // R1 reset levels
      idle_chk("R1 reset");
      chk("R1 rdata reset", {24'd0, rdata}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      idle_chk("R1 idle");
      for (int w = 0; w < 4; w++)
         for (int dir = 0; dir < 2; dir++)
            for (int sp = 0; sp < 2; sp++)
               for (int ai = 0; ai < 4; ai++)
                  run_txn(dir[0], sp[0], adrs[ai], 8'(8'hC3 ^ (w * 16 + ai)), w[1:0], 1'b0, 1'b0, 1'b0);
      // R10 request and inputs changed while busy
      run_txn(1'b0, 1'b1, 13'h1234, 8'h00, 2'd1, 1'b1, 1'b0, 1'b0);
      run_txn(1'b1, 1'b0, 13'h0F0F, 8'h96, 2'd2, 1'b1, 1'b0, 1'b0);
      // R8 request accepted in the done clock
      nx_we = 1'b0; nx_dm = 1'b1; nx_addr = 13'h1E01; nx_wdata = 8'h00; nx_wt = 2'd3;
      run_txn(1'b1, 1'b1, 13'h0321, 8'h7E, 2'd0, 1'b0, 1'b0, 1'b1);
      run_txn(1'b0, 1'b1, 13'h1E01, 8'h00, 2'd3, 1'b0, 1'b1, 1'b0);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule